// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

A monitoring block with two 32-bit event counters that software sets up and reads over a small register bus. Each counter has its own event-select field. A 64-entry vector of single-cycle event pulses feeds the block, and the select field picks one entry of that vector. A counter only advances when the processor's current privilege mode is enabled. The context-enable bits are shared by both counters, so the two counters cannot be started or stopped apart from each other. The counters use the top and bottom halves of a single 64-bit counter register.

When a counter moves from all-ones to zero, it sets its own sticky overflow flag. If interrupts are enabled, the flag raises the interrupt line. Software makes a counter overflow after exactly N events by writing it with the two's complement of N. Because the flags are kept per counter, software can tell an overflow on a counter it is not using apart from the one it cares about. Event index 63 never fires and serves as the idle event for a counter that is not in use.

Top module: `pmu_dual_ctr`

## Requirements
- R1: After reset, the control register, both counters, both overflow flags and irq are all zero.
- R2: Register map, with bus_rdata a combinational view of bus_addr. Address 0 is control: bits [5:0] select the low counter's event, bits [13:8] select the high counter's event, bit 16 enables user mode, bit 17 supervisor, bit 18 hypervisor, and bit 20 enables the interrupt. All other control bits read as zero. Address 1 holds the counters, low in [31:0] and high in [63:32]. Address 2 holds the overflow flags, bit 0 for the low counter and bit 1 for the high counter. A write changes only the bytes whose bus_be bit is set, so one event field can be changed without touching the other.
- R3: A counter adds exactly one at a clock edge when its selected ev_in bit is high and the enable bit for priv_mode is set. priv_mode encodes 0 as user, 1 as supervisor, 2 as hypervisor and 3 as a mode that never counts.
- R4: With all three context-enable bits clear, neither counter changes except through a bus write.
- R5: An increment from 0xFFFFFFFF wraps to zero and sets only that counter's overflow flag.
- R6: Overflow flags are sticky and are cleared by writing 1 to bit 0 or bit 1 at address 2 with bus_be[0] set. Writing 0 leaves a flag unchanged. If a wrap and a clear of the same flag land in the same cycle, the flag ends up set.
- R7: irq is high exactly when the interrupt-enable bit is set and at least one overflow flag is set.
- R8: A bus write to a counter half (any byte enable of that half) replaces the increment in that cycle. The other half keeps counting in the same cycle.
- R9: Selecting event 63 never advances a counter, even when ev_in is all ones.
- R10: Preloading a counter with the 32-bit two's complement of N makes it wrap on the Nth counted event and on no earlier event.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high (with bus_en) |
| bus_addr | input | 2 | Register address |
| bus_be | input | 8 | Byte enables for writes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr |
| priv_mode | input | 2 | Current privilege mode |
| ev_in | input | 64 | Event pulse vector |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situations to reach from the ports are the ones where two things land in the same cycle. One is a half-width counter write arriving while both counters are counting. Another is a wrap arriving in the same cycle as a write-1-to-clear of the same flag. Random counting from reset would almost never reach a wrap, so the stimulus preloads counters to within a few counts of all-ones. Directed steps then hold the event inputs high across the exact cycle of the bus write. The random phase keeps preloading values near the top, keeps the event inputs dense, and changes the privilege mode every cycle. This produces many wraps that overlap with writes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // control field positions
    localparam int LO_SEL_LSB = 0;
    localparam int HI_SEL_LSB = 8;
    localparam int USR_BIT    = 16;
    localparam int SUP_BIT    = 17;
    localparam int HYP_BIT    = 18;
    localparam int IRQ_BIT    = 20;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_OFF  = 2'd3
    } priv_e;

endpackage

// File: rtl/pmu_ctx_gate.sv
module pmu_ctx_gate
    import pmu_pkg::*;
(
    input  logic [1:0] priv_mode,
    input  logic       usr_en,
    input  logic       sup_en,
    input  logic       hyp_en,
    output logic       ctx_ok
);
    always_comb begin
        unique case (priv_e'(priv_mode))
            PRIV_USER: ctx_ok = usr_en;
            PRIV_SUP:  ctx_ok = sup_en;
            PRIV_HYP:  ctx_ok = hyp_en;
            default:   ctx_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_ev_select.sv
module pmu_ev_select #(
    parameter int NUM_EV = 64,
    parameter int SEL_W  = $clog2(NUM_EV)
) (
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);
    // topmost index is the idle event and is tied low
    logic [NUM_EV-1:0] ev_live;

    assign ev_live = {1'b0, ev_in[NUM_EV-2:0]};
    assign hit     = ev_live[sel];
endmodule

// File: rtl/pmu_cnt_step.sv
module pmu_cnt_step #(
    parameter int CNT_W = 32,
    localparam int NBYTE = CNT_W / 8
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             wr_en,
    input  logic [NBYTE-1:0] wr_be,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             inc,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);
    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (wr_en && (|wr_be)) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (wr_be[b]) nxt[b*8 +: 8] = wr_data[b*8 +: 8];
            end
        end else if (inc) begin
            nxt  = cur + CNT_W'(1);
            wrap = &cur;
        end
    end
endmodule

// File: rtl/pmu_dual_ctr.sv
module pmu_dual_ctr
    import pmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_EV = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_en,
    input  logic                   bus_we,
    input  logic [1:0]             bus_addr,
    input  logic [(2*CNT_W)/8-1:0] bus_be,
    input  logic [2*CNT_W-1:0]     bus_wdata,
    output logic [2*CNT_W-1:0]     bus_rdata,
    input  logic [1:0]             priv_mode,
    input  logic [NUM_EV-1:0]      ev_in,
    output logic                   irq
);
    localparam int DATA_W  = 2 * CNT_W;
    localparam int BE_W    = DATA_W / 8;
    localparam int HALF_BE = CNT_W / 8;
    localparam int SEL_W   = $clog2(NUM_EV);
    localparam int NCNT    = 2;

    typedef struct packed {
        logic [NCNT-1:0][SEL_W-1:0] sel;
        logic                       usr_en;
        logic                       sup_en;
        logic                       hyp_en;
        logic                       irq_en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [NCNT-1:0][CNT_W-1:0] cnt;
        logic [NCNT-1:0]            ovf;
    } state_t;

    state_t state_d, state_q;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] img;
        img = '0;
        img[LO_SEL_LSB +: SEL_W] = c.sel[0];
        img[HI_SEL_LSB +: SEL_W] = c.sel[1];
        img[USR_BIT] = c.usr_en;
        img[SUP_BIT] = c.sup_en;
        img[HYP_BIT] = c.hyp_en;
        img[IRQ_BIT] = c.irq_en;
        return img;
    endfunction

    // bus decode
    logic wr_any, ctrl_wr, cnt_wr, stat_wr;
    assign wr_any  = bus_en && bus_we;
    assign ctrl_wr = wr_any && (bus_addr == ADDR_CTRL);
    assign cnt_wr  = wr_any && (bus_addr == ADDR_CNT);
    assign stat_wr = wr_any && (bus_addr == ADDR_STAT);

    // shared context qualification
    logic ctx_ok;
    pmu_ctx_gate u_ctx (
        .priv_mode (priv_mode),
        .usr_en    (state_q.ctrl.usr_en),
        .sup_en    (state_q.ctrl.sup_en),
        .hyp_en    (state_q.ctrl.hyp_en),
        .ctx_ok    (ctx_ok)
    );

    // per-counter event pick and step
    logic [NCNT-1:0]            hit, wrap;
    logic [NCNT-1:0][CNT_W-1:0] cnt_nxt;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        pmu_ev_select #(.NUM_EV(NUM_EV), .SEL_W(SEL_W)) u_sel (
            .ev_in (ev_in),
            .sel   (state_q.ctrl.sel[i]),
            .hit   (hit[i])
        );
        pmu_cnt_step #(.CNT_W(CNT_W)) u_step (
            .cur     (state_q.cnt[i]),
            .wr_en   (cnt_wr),
            .wr_be   (bus_be[i*HALF_BE +: HALF_BE]),
            .wr_data (bus_wdata[i*CNT_W +: CNT_W]),
            .inc     (hit[i] && ctx_ok),
            .nxt     (cnt_nxt[i]),
            .wrap    (wrap[i])
        );
    end

    // next-state
    logic [DATA_W-1:0] ctrl_img;
    always_comb begin
        state_d  = state_q;
        ctrl_img = pack_ctrl(state_q.ctrl);
        if (ctrl_wr) begin
            for (int b = 0; b < BE_W; b++) begin
                if (bus_be[b]) ctrl_img[b*8 +: 8] = bus_wdata[b*8 +: 8];
            end
            state_d.ctrl.sel[0] = ctrl_img[LO_SEL_LSB +: SEL_W];
            state_d.ctrl.sel[1] = ctrl_img[HI_SEL_LSB +: SEL_W];
            state_d.ctrl.usr_en = ctrl_img[USR_BIT];
            state_d.ctrl.sup_en = ctrl_img[SUP_BIT];
            state_d.ctrl.hyp_en = ctrl_img[HYP_BIT];
            state_d.ctrl.irq_en = ctrl_img[IRQ_BIT];
        end
        state_d.cnt = cnt_nxt;
        for (int i = 0; i < NCNT; i++) begin
            if (stat_wr && bus_be[0] && bus_wdata[i]) state_d.ovf[i] = 1'b0;
            if (wrap[i]) state_d.ovf[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // read view
    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = pack_ctrl(state_q.ctrl);
            ADDR_CNT:  bus_rdata = {state_q.cnt[1], state_q.cnt[0]};
            ADDR_STAT: bus_rdata = {{(DATA_W-NCNT){1'b0}}, state_q.ovf};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = state_q.ctrl.irq_en && (|state_q.ovf);

    // flat views for the bound checker
    logic [CNT_W-1:0] cnt_lo_q, cnt_hi_q;
    logic [NCNT-1:0]  ovf_q;
    logic [SEL_W-1:0] sel_lo_q;
    logic [2:0]       ctx_en_q;
    assign cnt_lo_q = state_q.cnt[0];
    assign cnt_hi_q = state_q.cnt[1];
    assign ovf_q    = state_q.ovf;
    assign sel_lo_q = state_q.ctrl.sel[0];
    assign ctx_en_q = {state_q.ctrl.hyp_en, state_q.ctrl.sup_en, state_q.ctrl.usr_en};

endmodule

// File: rtl/pmu_dual_ctr_chk.sv
module pmu_dual_ctr_chk #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 6,
    localparam int BE_W = (2 * CNT_W) / 8,
    localparam int HALF_BE = CNT_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [2*CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt_lo,
    input logic [CNT_W-1:0]  cnt_hi,
    input logic [1:0]        ovf,
    input logic [SEL_W-1:0]  sel_lo,
    input logic [2:0]        ctx_en
);
    logic cwr, lo_wr, hi_wr, clr_lo;
    assign cwr    = bus_en && bus_we && (bus_addr == 2'd1);
    assign lo_wr  = cwr && (|bus_be[HALF_BE-1:0]);
    assign hi_wr  = cwr && (|bus_be[BE_W-1:HALF_BE]);
    assign clr_lo = bus_en && bus_we && (bus_addr == 2'd2) && bus_be[0] && bus_wdata[0];

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + CNT_W'(1)));

    // R4
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_en == 3'b000 && !lo_wr && !hi_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R5
    wrap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && (&cnt_lo)) |=> ((&cnt_lo) || (cnt_lo == '0 && ovf[0])));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !clr_lo) |=> ovf[0]);

    // R9
    idle_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&sel_lo) && !lo_wr) |=> $stable(cnt_lo));

endmodule

bind pmu_dual_ctr pmu_dual_ctr_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .cnt_lo    (cnt_lo_q),
    .cnt_hi    (cnt_hi_q),
    .ovf       (ovf_q),
    .sel_lo    (sel_lo_q),
    .ctx_en    (ctx_en_q)
);

// File: tb/pmu_dual_ctr_tb.sv
module pmu_dual_ctr_tb;
    localparam logic [63:0] CTRL_MASK = 64'h0000_0000_0017_3F3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_be = 8'h00;
    logic [63:0] bus_wdata = 64'h0;
    logic [63:0] bus_rdata;
    logic [1:0]  priv_mode = 2'd0;
    logic [63:0] ev_in = 64'h0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_ctrl = 64'h0;
    logic [63:0] m_cnt  = 64'h0;
    logic [1:0]  m_ovf  = 2'b0;

    always #4 clk = ~clk;

    pmu_dual_ctr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .priv_mode(priv_mode), .ev_in(ev_in), .irq(irq)
    );

    function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [7:0] be);
        logic [63:0] r = old;
        for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic bit ctx_ok(logic [63:0] c, logic [1:0] p);
        return (p == 2'd0 && c[16]) || (p == 2'd1 && c[17]) || (p == 2'd2 && c[18]);
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // model one clock edge from current inputs, then move to the next falling edge
    task automatic step();
        logic [63:0] n_ctrl = m_ctrl;
        logic [63:0] n_cnt  = m_cnt;
        logic [63:0] wm;
        logic [1:0]  n_ovf  = m_ovf;
        bit wr = bus_en && bus_we;
        if (wr && bus_addr == 2'd0) n_ctrl = merge(m_ctrl, bus_wdata, bus_be) & CTRL_MASK;
        if (wr && bus_addr == 2'd2 && bus_be[0]) n_ovf = m_ovf & ~bus_wdata[1:0];
        wm = merge(m_cnt, bus_wdata, bus_be);
        for (int i = 0; i < 2; i++) begin
            logic [5:0] sel = m_ctrl[i*8 +: 6];
            if (wr && bus_addr == 2'd1 && (|bus_be[i*4 +: 4])) begin
                n_cnt[i*32 +: 32] = wm[i*32 +: 32];
            end else if (sel != 6'd63 && ev_in[sel] && ctx_ok(m_ctrl, priv_mode)) begin
                n_cnt[i*32 +: 32] = m_cnt[i*32 +: 32] + 32'd1;
                if (m_cnt[i*32 +: 32] == 32'hFFFF_FFFF) n_ovf[i] = 1'b1;
            end
        end
        m_ctrl = n_ctrl; m_cnt = n_cnt; m_ovf = n_ovf;
        @(posedge clk);
        @(negedge clk);
        chk("R7 irq", {63'h0, irq}, {63'h0, m_ctrl[20] && (|m_ovf)});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] be, logic [63:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        step();
        bus_en = 1'b0; bus_we = 1'b0; bus_be = 8'h00;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [63:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0017);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 ctrl", 2'd0, 64'h0);
        rd("R1 cnt", 2'd1, 64'h0);
        rd("R1 stat", 2'd2, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);

        // R2 control layout, unused bits dropped
        wr(2'd0, 8'hFF, 64'h0000_0100_0001_0705);
        rd("R2 ctrl readback", 2'd0, 64'h0000_0000_0001_0705);

        // R3 counting in user mode
        priv_mode = 2'd0; ev_in = 64'h0;
        ev_in[5] = 1'b1;
        repeat (3) step();
        ev_in = 64'h0;
        rd("R3 user count", 2'd1, 64'h0000_0000_0000_0003);

        // R3 disabled modes do not count
        ev_in[5] = 1'b1; ev_in[7] = 1'b1;
        priv_mode = 2'd1; repeat (2) step();
        priv_mode = 2'd3; repeat (2) step();
        rd("R3 disabled mode", 2'd1, 64'h0000_0000_0000_0003);
        priv_mode = 2'd0; step();
        ev_in = 64'h0;
        rd("R3 both counters", 2'd1, 64'h0000_0001_0000_0004);

        // R2 byte-enable: change only high event field
        wr(2'd0, 8'h02, 64'h0000_0000_0000_0900);
        rd("R2 single field", 2'd0, 64'h0000_0000_0001_0905);

        // R8 low-half write wins, high half keeps counting
        ev_in[5] = 1'b1; ev_in[9] = 1'b1;
        wr(2'd1, 8'h0F, 64'h0000_0000_FFFF_FFFD);
        rd("R8 write wins", 2'd1, 64'h0000_0002_FFFF_FFFD);

        // R10 preload of -3 wraps on the third event
        repeat (2) step();
        rd("R10 no early wrap", 2'd2, 64'h0);
        step();
        ev_in = 64'h0;
        rd("R10 wrapped", 2'd1, 64'h0000_0005_0000_0000);
        rd("R5 low flag only", 2'd2, 64'h1);
        chk("R7 irq gated", {63'h0, irq}, 64'h0);

        // R7 enable interrupt
        wr(2'd0, 8'h04, 64'h0000_0000_0011_0000);
        chk("R7 irq raised", {63'h0, irq}, 64'h1);

        // R6 write 0 keeps, write 1 clears
        wr(2'd2, 8'h01, 64'h2);
        rd("R6 other bit no clear", 2'd2, 64'h1);
        wr(2'd2, 8'h01, 64'h1);
        rd("R6 cleared", 2'd2, 64'h0);
        chk("R7 irq dropped", {63'h0, irq}, 64'h0);

        // R6 set wins over clear, R5 high flag only
        wr(2'd1, 8'hF0, 64'hFFFF_FFFF_0000_0000);
        ev_in[9] = 1'b1;
        wr(2'd2, 8'h01, 64'h2);
        ev_in = 64'h0;
        rd("R5 high wrap", 2'd1, 64'h0);
        rd("R6 set wins", 2'd2, 64'h2);
        wr(2'd2, 8'h01, 64'h3);

        // R9 idle event
        wr(2'd0, 8'h03, 64'h0000_0000_0000_3F3F);
        ev_in = '1;
        repeat (4) step();
        ev_in = 64'h0;
        rd("R9 idle event", 2'd1, 64'h0);

        // R4 all enables clear
        wr(2'd0, 8'h07, 64'h0);
        ev_in = '1;
        for (int p = 0; p < 4; p++) begin
            priv_mode = 2'(p);
            step();
        end
        ev_in = 64'h0;
        rd("R4 stopped", 2'd1, 64'h0);

        // R3 hypervisor enable
        wr(2'd0, 8'h04, 64'h0000_0000_0004_0000);
        ev_in = '1; priv_mode = 2'd2;
        repeat (2) step();
        ev_in = 64'h0;
        rd("R3 hyp count", 2'd1, 64'h0000_0002_0000_0002);

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            ev_in = {$urandom(), $urandom()};
            priv_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 39) == 0) begin
                logic [1:0] a = 2'($urandom_range(0, 2));
                logic [63:0] d = {$urandom(), $urandom()};
                if (a == 2'd1) d = {28'hFFFF_FFF, d[35:32], 28'hFFFF_FFF, d[3:0]};
                if (a == 2'd0) d[22:16] = 7'h17;
                wr(a, 8'($urandom()), d);
            end else begin
                step();
            end
            if (n % 50 == 0) begin
                rd("R3 random cnt", 2'd1, m_cnt);
                rd("R5 random stat", 2'd2, {62'h0, m_ovf});
                rd("R2 random ctrl", 2'd0, m_ctrl);
            end
        end
        rd("R3 final cnt", 2'd1, m_cnt);
        rd("R6 final stat", 2'd2, {62'h0, m_ovf});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule